// File: doc/BRIEF.md
# Packed-Operand Bitwise Logic Unit

This unit performs one of four bitwise functions on two narrow operands. No separate opcode port exists. The most significant bit of each 4-bit operand is borrowed to build a 2-bit function code. The remaining three bits of each operand are the data that the function works on. The 3-bit answer is widened with zeros onto an 8-bit result bus.

The unit is one member of a larger arithmetic cluster. A unit-select input tells it when it is the chosen member. When it is not selected, its pipeline is cleared and its output sits at zero, so the unit does not toggle. An enable input freezes the pipeline in place.

Each operation passes through four register stages:
- capture of the inputs,
- decode of the function code and the data fields,
- evaluation of the function,
- the output register.

A new operation can enter on every enabled cycle.

Top module: `packed_logic_unit`

## Requirements
- R1: While `rstN` is low, `result` is 0. After `rstN` rises, `result` stays 0 until the first captured operation reaches the output.
- R2: When `opA[3]`=0 and `opB[3]`=0 (function code 00), `result[2:0]` is the bitwise AND of `opA[2:0]` and `opB[2:0]`.
- R3: When `opA[3]`=0 and `opB[3]`=1 (function code 01), `result[2:0]` is the bitwise OR of the two 3-bit fields.
- R4: When `opA[3]`=1 and `opB[3]`=0 (function code 10), `result[2:0]` is the inversion of `opA[2:0]`. The value of `opB[2:0]` has no effect on the result.
- R5: When `opA[3]`=1 and `opB[3]`=1 (function code 11), `result[2:0]` is the bitwise XOR of the two 3-bit fields.
- R6: `result[7:3]` is always zero.
- R7: Operands present before rising edge N, with `en`=1 and `unitSel`=1 at edges N to N+3, appear on `result` after edge N+3. Operations presented on consecutive cycles come out on consecutive cycles, in order.
- R8: While `en` is low and `unitSel` is high, every stage holds its value and `result` does not change. When `en` returns high, the held operations continue in order.
- R9: An edge with `unitSel` low clears every stage, regardless of `en`, and `result` reads 0 after that edge. After `unitSel` returns high, `result` stays 0 until newly captured operations arrive. Operations that were in flight are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Pipeline advance enable, active high |
| unitSel | input | 1 | Unit chosen; low clears the unit and forces zero output |
| opA | input | 4 | Operand A: bit 3 is the high function-code bit, bits 2:0 are data |
| opB | input | 4 | Operand B: bit 3 is the low function-code bit, bits 2:0 are data |
| result | output | 8 | Zero-extended 3-bit result |

## Verification
A faulty stage register shows up at `result` exactly as many cycles after the fault as there are stages left between it and the output. The worst case is three cycles, for a bad capture register. A wrong function code shows up as a wrong 3-bit pattern on the cycle its operation emerges. Operation streams that change every cycle expose a slipped or duplicated stage as values arriving one cycle early or late.

A hold fault shows as `result` moving while `en` is low. A clear fault shows as a stale nonzero value up to four cycles after `unitSel` falls or returns.

// File: rtl/pbl_pkg.sv
`timescale 1ns/1ps
package pbl_pkg;

  localparam int unsigned FUNC_W = 2;

  typedef enum logic [FUNC_W-1:0] {
    FN_AND = 2'b00,
    FN_OR  = 2'b01,
    FN_NOT = 2'b10,
    FN_XOR = 2'b11
  } funcSel_e;

  typedef struct packed {
    logic advance;
    logic clear;
  } pipeStrobe_t;

endpackage

// File: rtl/pbl_ctrl.sv
`timescale 1ns/1ps
module pbl_ctrl
  import pbl_pkg::*;
(
  input  logic        en,
  input  logic        unitSel,
  output pipeStrobe_t strb
);

  // Deselection outranks enable: a deselected unit is flushed even when frozen.
  always_comb begin
    strb.clear   = ~unitSel;
    strb.advance = unitSel & en;
  end

endmodule

// File: rtl/pbl_datapath.sv
`timescale 1ns/1ps
module pbl_datapath
  import pbl_pkg::*;
#(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pipeStrobe_t      strb,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [OUT_W-1:0] result
);

  localparam int unsigned FLD_W = OP_W - 1;
  localparam int unsigned PAD_W = OUT_W - FLD_W;

  // Stage 1: raw capture
  logic [OP_W-1:0]  s1A, s1B;
  // Stage 2: decoded function and data fields
  funcSel_e         s2Func;
  logic [FLD_W-1:0] s2A, s2B;
  // Stage 3: evaluated field
  logic [FLD_W-1:0] s3Res;
  logic [FLD_W-1:0] evalNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1A <= '0;
      s1B <= '0;
    end else if (strb.clear) begin
      s1A <= '0;
      s1B <= '0;
    end else if (strb.advance) begin
      s1A <= opA;
      s1B <= opB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Func <= FN_AND;
      s2A    <= '0;
      s2B    <= '0;
    end else if (strb.clear) begin
      s2Func <= FN_AND;
      s2A    <= '0;
      s2B    <= '0;
    end else if (strb.advance) begin
      s2Func <= funcSel_e'({s1A[OP_W-1], s1B[OP_W-1]});
      s2A    <= s1A[FLD_W-1:0];
      s2B    <= s1B[FLD_W-1:0];
    end
  end

  always_comb begin
    unique case (s2Func)
      FN_AND:  evalNext = s2A & s2B;
      FN_OR:   evalNext = s2A | s2B;
      FN_NOT:  evalNext = ~s2A;
      FN_XOR:  evalNext = s2A ^ s2B;
      default: evalNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              s3Res <= '0;
    else if (strb.clear)    s3Res <= '0;
    else if (strb.advance)  s3Res <= evalNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              result <= '0;
    else if (strb.clear)    result <= '0;
    else if (strb.advance)  result <= {{PAD_W{1'b0}}, s3Res};
  end

  // R4
  not_ignores_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && s2Func == FN_NOT) |=> (s3Res == ~$past(s2A)));

  // R5
  xor_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && s2Func == FN_XOR) |=> (s3Res == ($past(s2A) ^ $past(s2B))));

  // R7
  out_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (result[FLD_W-1:0] == $past(s3Res)));

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clear) |=> ($stable(result) && $stable(s1A) && $stable(s2A)));

  // R9
  deselect_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (result == '0 && s1A == '0 && s3Res == '0));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (result[OUT_W-1:FLD_W] == '0));

endmodule

// File: rtl/packed_logic_unit.sv
`timescale 1ns/1ps
module packed_logic_unit
  import pbl_pkg::*;
#(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             unitSel,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [OUT_W-1:0] result
);

  pipeStrobe_t strb;

  pbl_ctrl uCtrl (
    .en      (en),
    .unitSel (unitSel),
    .strb    (strb)
  );

  pbl_datapath #(
    .OP_W  (OP_W),
    .OUT_W (OUT_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: tb/tb_packed_logic_unit.sv
`timescale 1ns/1ps
module tb_packed_logic_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic       unitSel = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [7:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  packed_logic_unit dut (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .unitSel (unitSel),
    .opA     (opA),
    .opB     (opB),
    .result  (result)
  );

  function automatic logic [7:0] expOf(input logic [3:0] a, input logic [3:0] b);
    logic [2:0] r;
    case ({a[3], b[3]})
      2'b00:   r = a[2:0] & b[2:0];
      2'b01:   r = a[2:0] | b[2:0];
      2'b10:   r = ~a[2:0];
      default: r = a[2:0] ^ b[2:0];
    endcase
    return {5'b0, r};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Eight back-to-back operations; each checked four cycles after it is driven.
  task automatic runStream(input string req, input logic [31:0] aPk, input logic [31:0] bPk);
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      if (t >= 4) begin
        chk(req, result, expOf(aPk[(t-4)*4 +: 4], bPk[(t-4)*4 +: 4]));
        chk("R6 upper bits", {result[7:3], 3'b0}, 8'h00);
      end
      if (t < 8) begin
        opA = aPk[t*4 +: 4];
        opB = bPk[t*4 +: 4];
      end
    end
  endtask

  task automatic testReset();
    chk("R1 in reset", result, 8'h00);
    @(negedge clk);
    en = 1'b1; unitSel = 1'b1;
    opA = 4'b0111; opB = 4'b0110;      // AND -> 110
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 after release", result, 8'h00);
    end
    @(negedge clk);
    chk("R1 first op", result, 8'h06);
  endtask

  task automatic testFunctions();
    runStream("R2 AND", 32'h7531_6370, 32'h6073_5147);
    runStream("R3 OR",  32'h0124_6517, 32'h8A9C_DB8E);
    runStream("R4 NOT", 32'hF9AC_8BDE, 32'h7031_6254);
    runStream("R5 XOR", 32'hF9AC_8BDE, 32'h8FAB_CDE9);
    runStream("R7 mixed", 32'hE0C5_9F3A, 32'h0BF8_7E1C);
  endtask

  task automatic testNotIgnoresB();
    // same opA, different opB fields, code 10 each time
    runStream("R4 opB ignored", 32'hAAAA_AAAA, 32'h7654_3210);
  endtask

  task automatic testLatency();
    @(negedge clk);
    opA = 4'b0101; opB = 4'b0011;      // AND -> 001
    repeat (5) @(negedge clk);
    opA = 4'b1110; opB = 4'b1011;      // XOR -> 101
    @(negedge clk);
    opA = 4'b0101; opB = 4'b0011;
    chk("R7 edge1", result, 8'h01);
    @(negedge clk); chk("R7 edge2", result, 8'h01);
    @(negedge clk); chk("R7 edge3", result, 8'h01);
    @(negedge clk); chk("R7 edge4", result, 8'h05);
    @(negedge clk); chk("R7 edge5", result, 8'h01);
  endtask

  task automatic testEnableHold();
    @(negedge clk); opA = 4'b0101; opB = 4'b0011;   // 001
    @(negedge clk); opA = 4'b0101; opB = 4'b1011;   // 111
    @(negedge clk); opA = 4'b1100; opB = 4'b0000;   // 011
    @(negedge clk); opA = 4'b1110; opB = 4'b1011;   // 101
    @(negedge clk);
    chk("R8 before freeze", result, 8'h01);
    en = 1'b0; opA = 4'b1111; opB = 4'b1111;
    @(negedge clk); chk("R8 frozen 1", result, 8'h01);
    @(negedge clk); chk("R8 frozen 2", result, 8'h01);
    en = 1'b1; opA = 4'b0110; opB = 4'b0010;        // 010
    @(negedge clk); chk("R8 resume op1", result, 8'h07);
    @(negedge clk); chk("R8 resume op2", result, 8'h03);
    @(negedge clk); chk("R8 resume op3", result, 8'h05);
    @(negedge clk); chk("R8 resume op4", result, 8'h02);
  endtask

  task automatic testDeselect();
    @(negedge clk); opA = 4'b0101; opB = 4'b0011;   // 001
    @(negedge clk); opA = 4'b0101; opB = 4'b1011;   // 111
    @(negedge clk); opA = 4'b1100; opB = 4'b0000;   // 011
    @(negedge clk);
    unitSel = 1'b0; en = 1'b0; opA = 4'b1110; opB = 4'b1011;
    @(negedge clk); chk("R9 cleared", result, 8'h00);
    @(negedge clk); chk("R9 held clear", result, 8'h00);
    unitSel = 1'b1; en = 1'b1; opA = 4'b0110; opB = 4'b0010;   // 010
    @(negedge clk); chk("R9 flushed 1", result, 8'h00);
    @(negedge clk); chk("R9 flushed 2", result, 8'h00);
    @(negedge clk); chk("R9 flushed 3", result, 8'h00);
    @(negedge clk); chk("R9 new op", result, 8'h02);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    testReset();
    testFunctions();
    testNotIgnoresB();
    testLatency();
    testEnableHold();
    testDeselect();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule